// File: doc/BRIEF.md
# Conversion-complete flag register

This block keeps one completion flag for each of eight result registers of a multi-channel analog-to-digital converter. An end-of-conversion strobe carries a channel index and a result byte. The strobe stores the byte in that channel's result register and raises that channel's flag. A single-cycle bus reads the packed status byte or any result register. Software uses the flags to learn which results are new.

A mode input selects how a flag is cleared. In fast-clear mode, reading a result register clears its flag. In two-step mode, a status read first arms every flag that is set at that moment. A later result read then clears the flag, but only if that channel is armed. A new conversion on a channel drops its arming.

The block also holds a 10-bit successive-approximation value behind a two-byte test register. The test register is reachable only while a special-mode input is high. The current value is always visible on an output port.

Top module: `ccf_bank`

## Requirements
- R1: After reset, all flags, arming bits, result registers, the test value and `rdata` are zero.
- R2: An end-of-conversion strobe (`eoc_valid`) stores `eoc_data` in result register `eoc_chan` and sets flag `eoc_chan`.
- R3: A read of address 0 returns the flags on `rdata` in the next cycle, with bit n holding channel n and the value taken before that cycle's update.
- R4: A read of address 8+n returns result register n on `rdata` in the next cycle.
- R5: With `fast_clr` = 1, a read of address 8+n clears flag n, whether or not a status read came first.
- R6: With `fast_clr` = 0, a status read arms every flag that is set at that time. A read of address 8+n clears flag n only if channel n is armed; otherwise the flag is left unchanged. Clearing a flag also drops its arming.
- R7: An end-of-conversion strobe on channel n clears the arming of channel n. A later result read in two-step mode therefore leaves flag n set until another status read arms it.
- R8: If an end-of-conversion strobe and a clearing result read hit the same channel in the same cycle, the flag ends at 1.
- R9: With `special_mode` = 1, address 1 reads and writes test bits [9:2] as a byte. Address 2 reads and writes test bits [1:0] in byte bits [7:6], and its bits [5:0] read as zero. `sar_value` shows the stored value.
- R10: With `special_mode` = 0, reads of addresses 1 and 2 return zero and writes to them leave the test value unchanged.
- R11: Reads of addresses 3 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_clr | input | 1 | 1 selects fast clear, 0 selects two-step clear |
| special_mode | input | 1 | Enables access to the test register |
| eoc_valid | input | 1 | End-of-conversion strobe |
| eoc_chan | input | 3 | Channel index of the finished conversion |
| eoc_data | input | 8 | Result byte of the finished conversion |
| rd_en | input | 1 | Single-cycle read strobe |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 4 | 0 status, 1 test high, 2 test low, 8 to 15 results |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| sar_value | output | 10 | Current test value |

## Verification
The hardest state to reach is a two-step clear that goes wrong for a reason other than a missing status read. One case is a channel that is armed and then takes a new conversion before its result is read. Another is a strobe and a clearing read that meet on one channel in the same cycle. Random traffic seldom lines these up, so directed sequences build each one: set flag, status read, new strobe, result read. The random phase keeps only eight channels and a high share of status and result reads, so arming and clearing happen often in both modes.

// File: rtl/ccf_bank.sv
module ccf_bank #(
  parameter int NCH   = 8,
  parameter int RES_W = 8,
  parameter int SAR_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fast_clr,
  input  logic                     special_mode,
  input  logic                     eoc_valid,
  input  logic [$clog2(NCH)-1:0]   eoc_chan,
  input  logic [RES_W-1:0]         eoc_data,
  input  logic                     rd_en,
  input  logic                     wr_en,
  input  logic [3:0]               addr,
  input  logic [7:0]               wdata,
  output logic [7:0]               rdata,
  output logic [SAR_W-1:0]         sar_value
);
  localparam int CW   = $clog2(NCH);
  localparam int LO_W = SAR_W - 8;

  logic [NCH-1:0]   flag_q, arm_q;
  logic [RES_W-1:0] res_q [NCH];
  logic [SAR_W-1:0] sar_q;
  logic [7:0]       rd_mux;

  wire [CW-1:0]  rch     = addr[CW-1:0];
  wire           res_rd  = rd_en && addr[3];
  wire           stat_rd = rd_en && (addr == 4'h0);
  wire [NCH-1:0] set_m   = eoc_valid ? (NCH'(1) << eoc_chan) : '0;
  wire [NCH-1:0] sel_m   = res_rd ? (NCH'(1) << rch) : '0;
  wire [NCH-1:0] clr_m   = sel_m & (fast_clr ? {NCH{1'b1}} : arm_q);
  wire           tw_hi   = wr_en && special_mode && (addr == 4'h1);
  wire           tw_lo   = wr_en && special_mode && (addr == 4'h2);

  assign sar_value = sar_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      arm_q  <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_m) | set_m;
      arm_q  <= (arm_q | (stat_rd ? flag_q : '0)) & ~clr_m & ~set_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) res_q[i] <= '0;
    end else if (eoc_valid) begin
      res_q[eoc_chan] <= eoc_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sar_q <= '0;
    else begin
      if (tw_hi) sar_q[SAR_W-1 -: 8] <= wdata;
      if (tw_lo) sar_q[LO_W-1:0]     <= wdata[7 -: LO_W];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr[3])                           rd_mux = 8'(res_q[rch]);
    else if (addr == 4'h0)                 rd_mux = 8'(flag_q);
    else if (addr == 4'h1 && special_mode) rd_mux = sar_q[SAR_W-1 -: 8];
    else if (addr == 4'h2 && special_mode) rd_mux = {sar_q[LO_W-1:0], {(8-LO_W){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_valid |=> flag_q[$past(eoc_chan)] && !arm_q[$past(eoc_chan)]); // R8
  AST_FAST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (res_rd && fast_clr && !(eoc_valid && eoc_chan == rch)) |=> !flag_q[$past(rch)]); // R5
  AST_ARM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_rd && !fast_clr && !arm_q[rch] && !eoc_valid) |=> flag_q[$past(rch)] == $past(flag_q[rch])); // R6
  AST_STATUS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> rdata == 8'($past(flag_q))); // R3
  AST_TEST_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !special_mode) |=> sar_q == $past(sar_q)); // R10
endmodule

// File: tb/sim_ccf_bank.sv
module sim_ccf_bank;
  logic clk = 0, rst_n = 0, fast_clr = 0, special_mode = 0;
  logic eoc_valid = 0, rd_en = 0, wr_en = 0;
  logic [2:0] eoc_chan = 0;
  logic [7:0] eoc_data = 0, wdata = 0;
  logic [3:0] addr = 0;
  logic [7:0] rdata;
  logic [9:0] sar_value;

  int checks = 0, fails = 0;
  logic [7:0] m_flag = 0, m_arm = 0;
  logic [7:0] m_res [8];
  logic [9:0] m_sar = 0;

  ccf_bank u0 (.clk, .rst_n, .fast_clr, .special_mode, .eoc_valid, .eoc_chan,
               .eoc_data, .rd_en, .wr_en, .addr, .wdata, .rdata, .sar_value);

  always #5 clk = ~clk;

  initial begin
    #1500000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [3:0] a, logic sp);
    if (a[3]) return m_res[a[2:0]];
    if (a == 0) return m_flag;
    if (a == 1 && sp) return m_sar[9:2];
    if (a == 2 && sp) return {m_sar[1:0], 6'b0};
    return 8'h00;
  endfunction

  function automatic string rtag(logic [3:0] a);
    if (a[3]) return "R4";
    if (a == 0) return "R3";
    if (a == 1 || a == 2) return "R9/R10";
    return "R11";
  endfunction

  task automatic op(logic rd, logic wr, logic [3:0] a, logic [7:0] wd,
                    logic ev, logic [2:0] ch, logic [7:0] d);
    logic [7:0] e, clr, set;
    @(negedge clk);
    rd_en = rd; wr_en = wr; addr = a; wdata = wd;
    eoc_valid = ev; eoc_chan = ch; eoc_data = d;
    e = rd ? exp_read(a, special_mode) : rdata;
    set = ev ? (8'd1 << ch) : 8'd0;
    clr = (rd && a[3]) ? ((8'd1 << a[2:0]) & (fast_clr ? 8'hff : m_arm)) : 8'd0;
    m_arm = (m_arm | ((rd && a == 0) ? m_flag : 8'd0)) & ~clr & ~set;
    m_flag = (m_flag & ~clr) | set;
    if (ev) m_res[ch] = d;
    if (wr && special_mode && a == 1) m_sar[9:2] = wd;
    if (wr && special_mode && a == 2) m_sar[1:0] = wd[7:6];
    @(posedge clk); #1;
    if (rd) chk(rtag(a), rdata, e);
    chk("R9/R10 sar", sar_value, m_sar);
    rd_en = 0; wr_en = 0; eoc_valid = 0;
  endtask

  task automatic status_is(string tag, logic [7:0] exp);
    op(1, 0, 0, 0, 0, 0, 0);
    chk(tag, rdata, exp);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_res[i] = 0;
    repeat (3) @(posedge clk);
    #1 chk("R1 rdata", rdata, 0);
    chk("R1 sar", sar_value, 0);
    @(negedge clk) rst_n = 1;
    status_is("R1 flags", 8'h00);
    for (int i = 0; i < 8; i++) op(1, 0, 4'(8 + i), 0, 0, 0, 0);

    fast_clr = 1;
    op(0, 0, 0, 0, 1, 3, 8'h5a);
    status_is("R2 set", 8'h08);
    op(1, 0, 4'hb, 0, 0, 0, 0);
    chk("R4 result", rdata, 8'h5a);
    status_is("R5 fast clear", 8'h00);
    op(0, 0, 0, 0, 1, 6, 8'h11);
    op(1, 0, 4'he, 0, 1, 6, 8'h22);
    status_is("R8 set wins", 8'h40);

    fast_clr = 0;
    op(0, 0, 0, 0, 1, 1, 8'h33);
    op(1, 0, 4'h9, 0, 0, 0, 0);
    status_is("R6 unarmed read keeps flag", 8'h42);
    op(1, 0, 4'h9, 0, 0, 0, 0);
    status_is("R6 armed read clears", 8'h40);
    op(0, 0, 0, 0, 1, 6, 8'h44);
    op(1, 0, 4'he, 0, 0, 0, 0);
    status_is("R7 new conversion drops arming", 8'h40);
    op(1, 0, 4'he, 0, 1, 6, 8'h55);
    status_is("R8 set wins two-step", 8'h40);

    special_mode = 0;
    op(0, 1, 1, 8'hff, 0, 0, 0);
    op(0, 1, 2, 8'hc0, 0, 0, 0);
    chk("R10 write ignored", sar_value, 0);
    special_mode = 1;
    op(0, 1, 1, 8'ha5, 0, 0, 0);
    op(0, 1, 2, 8'h7f, 0, 0, 0);
    chk("R9 write", sar_value, 10'h295);
    op(1, 0, 2, 0, 0, 0, 0);
    chk("R9 low read", rdata, 8'h40);
    special_mode = 0;
    op(1, 0, 1, 0, 0, 0, 0);
    chk("R10 read zero", rdata, 0);
    op(1, 0, 5, 0, 0, 0, 0);
    chk("R11 unmapped", rdata, 0);

    void'($urandom(32'h1d2c));
    for (int n = 0; n < 4000; n++) begin
      int k;
      logic [3:0] a;
      k = $urandom_range(0, 99);
      if (k < 3) fast_clr = ~fast_clr;
      if (k >= 3 && k < 5) special_mode = ~special_mode;
      a = (k < 30) ? 4'h0 : (k < 75) ? 4'(8 + $urandom_range(0, 7)) : 4'($urandom_range(0, 15));
      op($urandom_range(0, 2) != 0, $urandom_range(0, 5) == 0, a, 8'($urandom),
         $urandom_range(0, 2) == 0, 3'($urandom_range(0, 7)), 8'($urandom));
    end
    status_is("R6 final flags", m_flag);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule